// File: doc/BRIEF.md
# Word and Byte Framing Strobe Generator

This block frames a serial bit stream by running one free-running phase counter and decoding two strobes from it. A one-cycle word strobe marks the last bit of every 32-bit word. A one-cycle byte strobe marks the last bit of every 8-bit byte. Both strobes come from the same counter, so they stay nested and in phase.

Logic that has found a boundary in an incoming stream drives the active-low sync input. While sync is low, the counter takes a caller-chosen preset phase instead of zero. This aligns the framing to the stream without having to wait for a wrap. An enable input pauses the framing. A synchronous reset returns the counter to phase zero.

Top module: `frame_strobe_gen`

## Requirements
- R1: While `rst` is high, both strobes are low. The count is cleared to 0, so after reset is released with sync high and enable high, the first byte strobe comes 7 cycles later and the first word strobe 31 cycles later.
- R2: With sync high and enable high, `word_stb` is high for exactly one cycle in every 32, in the cycle where the 5-bit count equals 31.
- R3: With sync high and enable high, `byte_stb` is high for exactly one cycle in every 8, in the cycle where the low 3 bits of the count equal 7.
- R4: Every cycle with `word_stb` high also has `byte_stb` high.
- R5: While `sync_n` is low, the count is loaded with `preset` at every rising edge, and both strobes are low.
- R6: After `sync_n` returns high with enable high, counting resumes from `preset`. The first word strobe falls 31 − `preset` cycles after the first cycle with sync high. The first byte strobe falls 7 − `preset[2:0]` cycles after it. A preset of 31 gives a word strobe in that first cycle.
- R7: While `en` is low (with sync high), the count holds its value and both strobes are low. Counting resumes from the held value when `en` returns high.
- R8: Reset takes priority over sync, and sync takes priority over enable. A low `sync_n` loads the preset even while `en` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst | input | 1 | Synchronous active-high reset, clears the count to 0 |
| sync_n | input | 1 | Active-low alignment request, loads the preset phase |
| en | input | 1 | Count enable; low freezes the count and mutes the strobes |
| preset | input | 5 | Phase loaded while sync is low |
| word_stb | output | 1 | One-cycle pulse on the last bit of each 32-bit word |
| byte_stb | output | 1 | One-cycle pulse on the last bit of each 8-bit byte |

## Verification
The bench releases sync with the presets 0, 20 and 31 and measures the delay to the first strobes. A design with an off-by-one between the load and the step, or one that clears to zero, would show the wrong delay. It pauses the enable both mid-word and on the very cycle where the count is 31. A design that let a strobe leak through, or that advanced the count while paused, would then strobe at the wrong time or twice. It also drives sync low with the enable low, and drives sync low during reset. A design with the wrong priority would keep the frozen phase or take the preset instead of zero.

// File: rtl/frame_pkg.sv
package frame_pkg;
  // What the phase counter does at the next rising edge.
  typedef enum logic [1:0] {
    PH_CLEAR = 2'd0,
    PH_LOAD  = 2'd1,
    PH_STEP  = 2'd2,
    PH_HOLD  = 2'd3
  } phase_act_e;
endpackage

// File: rtl/frame_phase_ctrl.sv
module frame_phase_ctrl
  import frame_pkg::*;
(
  input  logic       rst,
  input  logic       sync_n,
  input  logic       en,
  output phase_act_e act,
  output logic       run
);
  // Priority: reset, then sync, then enable.
  always_comb begin
    if (rst)          act = PH_CLEAR;
    else if (!sync_n) act = PH_LOAD;
    else if (en)      act = PH_STEP;
    else              act = PH_HOLD;
  end

  // Strobes may only be issued in a cycle where the counter advances.
  assign run = (act == PH_STEP);
endmodule

// File: rtl/frame_phase_counter.sv
module frame_phase_counter
  import frame_pkg::*;
#(
  parameter int CNT_W = 5
) (
  input  logic             clk,
  input  phase_act_e       act,
  input  logic [CNT_W-1:0] preset,
  output logic [CNT_W-1:0] cnt
);
  // The step wraps naturally at 2**CNT_W.
  function automatic logic [CNT_W-1:0] next_phase(input logic [CNT_W-1:0] cur);
    return cur + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    case (act)
      PH_CLEAR: cnt <= '0;
      PH_LOAD:  cnt <= preset;
      PH_STEP:  cnt <= next_phase(cnt);
      default:  cnt <= cnt;
    endcase
  end
endmodule

// File: rtl/frame_strobe_decode.sv
module frame_strobe_decode #(
  parameter int CNT_W    = 5,
  parameter int BYTE_LOG = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic [CNT_W-1:0] cnt,
  output logic             word_stb,
  output logic             byte_stb
);
  function automatic logic at_word_end(input logic [CNT_W-1:0] c);
    return &c;
  endfunction

  function automatic logic at_byte_end(input logic [CNT_W-1:0] c);
    return &c[BYTE_LOG-1:0];
  endfunction

  logic word_end, byte_end;
  assign word_end = at_word_end(cnt);
  assign byte_end = at_byte_end(cnt);

  assign word_stb = run & word_end;
  assign byte_stb = run & byte_end;

  // R4: a word boundary is always also a byte boundary
  p_nest_r4: assert property (@(posedge clk) disable iff (rst)
    word_stb |-> byte_stb);
  // R2: the word strobe never lasts two cycles
  p_word_single_r2: assert property (@(posedge clk) disable iff (rst)
    word_stb |=> !word_stb);
endmodule

// File: rtl/frame_strobe_gen.sv
module frame_strobe_gen #(
  parameter int BYTE_LOG = 3,
  parameter int WORD_LOG = 5
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                sync_n,
  input  logic                en,
  input  logic [WORD_LOG-1:0] preset,
  output logic                word_stb,
  output logic                byte_stb
);
  import frame_pkg::*;

  localparam int CNT_W = WORD_LOG;

  phase_act_e       act;
  logic             run;
  logic [CNT_W-1:0] cnt;

  frame_phase_ctrl u_ctrl (
    .rst    (rst),
    .sync_n (sync_n),
    .en     (en),
    .act    (act),
    .run    (run)
  );

  frame_phase_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk    (clk),
    .act    (act),
    .preset (preset),
    .cnt    (cnt)
  );

  frame_strobe_decode #(.CNT_W(CNT_W), .BYTE_LOG(BYTE_LOG)) u_dec (
    .clk      (clk),
    .rst      (rst),
    .run      (run),
    .cnt      (cnt),
    .word_stb (word_stb),
    .byte_stb (byte_stb)
  );

  // R1: both strobes stay quiet during reset
  always_comb begin
    if (rst) begin
      p_reset_quiet_r1: assert (!word_stb && !byte_stb);
    end
  end

  // R5: a low sync loads the preset phase
  p_sync_load_r5: assert property (@(posedge clk) disable iff (rst)
    !sync_n |=> cnt == $past(preset));
  // R5: no strobes while sync is low
  p_sync_quiet_r5: assert property (@(posedge clk) disable iff (rst)
    !sync_n |-> (!word_stb && !byte_stb));
  // R7: a paused counter keeps its phase
  p_hold_r7: assert property (@(posedge clk) disable iff (rst)
    (sync_n && !en) |=> $stable(cnt));
  // R7: a paused counter issues no strobes
  p_hold_quiet_r7: assert property (@(posedge clk) disable iff (rst)
    !en |-> (!word_stb && !byte_stb));
  // R2: a running counter advances by one each cycle
  p_step_r2: assert property (@(posedge clk) disable iff (rst)
    (sync_n && en) |=> cnt == CNT_W'($past(cnt) + 1'b1));
endmodule

// File: tb/frame_strobe_gen_bench.sv
module frame_strobe_gen_bench;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       sync_n = 1'b1;
  logic       en = 1'b1;
  logic [4:0] preset = 5'd0;
  logic       word_stb, byte_stb;

  int total = 0;
  int bad = 0;
  int m_cnt = 0;
  logic last_w, last_b;

  always #4 clk = ~clk;

  frame_strobe_gen u_frame_strobe_gen (
    .clk(clk), .rst(rst), .sync_n(sync_n), .en(en), .preset(preset),
    .word_stb(word_stb), .byte_stb(byte_stb)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // One clock: drive at negedge, compare strobes against the model, advance the model.
  task automatic step(input logic r, input logic s, input logic e, input logic [4:0] p,
                      input string tag);
    logic ew, eb;
    @(negedge clk);
    rst = r; sync_n = s; en = e; preset = p;
    #1;
    ew = !r && s && e && (m_cnt == 31);
    eb = !r && s && e && ((m_cnt % 8) == 7);
    chk(word_stb === ew, {tag, " word_stb"}, int'(word_stb), int'(ew));
    chk(byte_stb === eb, {tag, " byte_stb"}, int'(byte_stb), int'(eb));
    if (word_stb) chk(byte_stb === 1'b1, "R4 nesting", int'(byte_stb), 1);
    last_w = word_stb;
    last_b = byte_stb;
    @(posedge clk);
    if (r) m_cnt = 0;
    else if (!s) m_cnt = int'(p);
    else if (e) m_cnt = (m_cnt + 1) % 32;
  endtask

  // Run with sync high and enable high; check the delay to the first strobes.
  task automatic measure(input int exp_w, input int exp_b, input string tag);
    int fw = -1;
    int fb = -1;
    for (int k = 0; k < 40; k++) begin
      step(1'b0, 1'b1, 1'b1, 5'd0, tag);
      if (last_w && fw < 0) fw = k;
      if (last_b && fb < 0) fb = k;
    end
    chk(fw == exp_w, {tag, " first word delay"}, fw, exp_w);
    chk(fb == exp_b, {tag, " first byte delay"}, fb, exp_b);
  endtask

  task automatic t_reset;
    for (int k = 0; k < 3; k++) step(1'b1, 1'b1, 1'b1, 5'd13, "R1 in reset");
    measure(31, 7, "R1 from reset");
  endtask

  task automatic t_free_run;
    int nw = 0;
    int nb = 0;
    for (int k = 0; k < 64; k++) begin
      step(1'b0, 1'b1, 1'b1, 5'd0, "R2 R3 free run");
      nw += int'(last_w);
      nb += int'(last_b);
    end
    chk(nw == 2, "R2 word strobes in 64 cycles", nw, 2);
    chk(nb == 8, "R3 byte strobes in 64 cycles", nb, 8);
  endtask

  task automatic t_sync(input logic [4:0] p);
    for (int k = 0; k < 3; k++) step(1'b0, 1'b0, 1'b1, p, "R5 sync low");
    measure(31 - int'(p), (7 - int'(p[2:0])), "R6 after sync");
  endtask

  task automatic t_enable;
    step(1'b0, 1'b0, 1'b1, 5'd29, "R5 align");
    step(1'b0, 1'b1, 1'b1, 5'd0, "R7 run");
    step(1'b0, 1'b1, 1'b1, 5'd0, "R7 run");
    for (int k = 0; k < 5; k++) step(1'b0, 1'b1, 1'b0, 5'd0, "R7 paused at 31");
    measure(0, 0, "R7 resume at 31");
    step(1'b0, 1'b0, 1'b1, 5'd10, "R5 align");
    for (int k = 0; k < 4; k++) step(1'b0, 1'b1, 1'b0, 5'd0, "R7 paused mid-word");
    measure(21, 5, "R7 resume mid-word");
  endtask

  task automatic t_priority;
    step(1'b0, 1'b0, 1'b0, 5'd25, "R8 sync over enable");
    step(1'b0, 1'b1, 1'b0, 5'd0, "R8 paused");
    measure(6, 6, "R8 sync over enable");
    step(1'b1, 1'b0, 1'b1, 5'd9, "R8 reset over sync");
    measure(31, 7, "R8 reset over sync");
  endtask

  initial begin
    #(8 * 100000);
    bad++;
    total++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    t_reset();
    t_free_run();
    t_sync(5'd20);
    t_sync(5'd31);
    t_sync(5'd0);
    t_enable();
    t_priority();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule